// File: doc/BRIEF.md
# Raster Line and Frame Timer with Line Interrupt

This block produces the horizontal and vertical raster timing for a tile-based video controller. A master clock is divided by a fixed number of clocks per dot. A dot counter runs across each line and a line counter runs across each frame. From these two counters the block derives a horizontal blanking flag, a vertical blanking flag and a display-active flag. Each line opens with its blanking dots, and the drawn dots follow.

A display-enable input is taken into the timing only once per line, at the moment the blanking part of the line ends. Software that clears the enable while a line is being drawn therefore still gets that whole line. If it clears the enable during blanking, the line that is about to be drawn comes out blank. The counters keep running whatever the enable is, so the monitor never loses lock.

A down-counting line interrupt raises a one-clock pulse at the start of the blanking that follows every (interval+1)-th visible line. The pulse arrives before the enable is sampled for the next line, so a handler that runs in that blanking can still change the following line.

Top module: `raster_timer`

## Requirements
- R1: The dot counter advances by one every CLK_PER_DOT clocks, runs from 0 to DOTS_PER_LINE-1 and then wraps to 0. Dot 0 of line 0 starts on the first clock after reset.
- R2: The line counter advances by one when the dot counter wraps, and it returns to 0 after line TOTAL_LINES-1.
- R3: hblank is high exactly while the dot counter is below HBLANK_DOTS, that is, over the first HBLANK_DOTS dots of every line.
- R4: vblank is high exactly while the line counter is VISIBLE_LINES or greater.
- R5: The display-enable input is sampled only on the clock edge that ends the last blanking dot of a line. A change that arrives while a line is being drawn has no effect on that line.
- R6: A change of display-enable made during blanking takes effect on the drawn part of the same line, which is the line that follows the line interrupt.
- R7: active is high exactly when hblank is low, vblank is low and the sampled enable is 1.
- R8: The dot and line counters keep running while display-enable is 0.
- R9: At the end of each visible line, a zero interrupt counter produces a pulse of one clock and the counter reloads from the interval input. A non-zero counter decrements instead. The pulse is high in the first clock of the next line (dot 0). An interval of 0 interrupts after every visible line, and an interval of 1 after every second visible line.
- R10: At the end of every line in vertical blanking, the interrupt counter reloads from the interval input and no pulse is raised. As a result, each frame counts from a fresh interval.
- R11: During reset and right after it, the dot and line counters are 0, the sampled enable and the interrupt counter are 0, and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_en_i | input | 1 | Display enable, sampled once per line |
| irq_interval_i | input | IRQ_W | Line-interrupt interval minus one |
| dot_o | output | DOT_W | Dot position within the line |
| line_o | output | LINE_W | Line position within the frame |
| hblank_o | output | 1 | Horizontal blanking flag |
| vblank_o | output | 1 | Vertical blanking flag |
| active_o | output | 1 | Pixel drawing permitted |
| line_irq_o | output | 1 | One-clock line-interrupt pulse |

## Verification
The counters and the blanking flags follow from the number of clocks since reset. Dot and line change one clock after the edge that ends a dot period, and the flags decode combinationally from those registers. The sampled enable takes one register stage at the end of hblank, so active shows its new value on the first drawn dot. The interrupt pulse is registered on the edge that wraps the line, so it coincides with dot 0 of the new line. The bench keeps its own clock count, derives every expected value from that count and from its own enable and counter state, which it updates at the same edges, and compares all outputs at the falling edge of every cycle. Directed cases count pulses per frame and place enable changes inside blanking and inside drawing.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Horizontal blanking occupies the leading dots of a line.
  function automatic logic dot_in_hblank(int unsigned dot, int unsigned hb_dots);
    return dot < hb_dots;
  endfunction

  // Vertical blanking occupies the lines after the visible ones.
  function automatic logic line_in_vblank(int unsigned line, int unsigned vis_lines);
    return line >= vis_lines;
  endfunction

  // Width of a counter that must hold values 0..n-1 (at least one bit).
  function automatic int unsigned cnt_width(int unsigned n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/raster_dot_gen.sv
module raster_dot_gen
  import raster_pkg::*;
#(
  parameter int CLK_PER_DOT   = 10,
  parameter int DOTS_PER_LINE = 342,
  parameter int HBLANK_DOTS   = 86,
  parameter int DOT_W         = cnt_width(DOTS_PER_LINE)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [DOT_W-1:0] dot_o,
  output logic             tick_o,
  output logic             line_end_o,
  output logic             hb_end_o
);
  localparam logic [DOT_W-1:0] DOT_LAST = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [DOT_W-1:0] HB_LAST  = DOT_W'(HBLANK_DOTS - 1);

  logic [DOT_W-1:0] dot_q;

  generate
    if (CLK_PER_DOT == 1) begin : g_no_div
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PRE_W = cnt_width(CLK_PER_DOT);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_DOT - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                       pre_q <= pre_q + PRE_W'(1);
      end
      assign tick_o = (pre_q == PRE_LAST);
    end
  endgenerate

  assign line_end_o = tick_o && (dot_q == DOT_LAST);
  assign hb_end_o   = tick_o && (dot_q == HB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dot_q <= '0;
    else if (line_end_o) dot_q <= '0;
    else if (tick_o)     dot_q <= dot_q + DOT_W'(1);
  end

  assign dot_o = dot_q;

  a_r1_dot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !line_end_o) |=> dot_q == $past(dot_q) + DOT_W'(1));
  a_r1_dot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(dot_q));
  a_r1_dot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    line_end_o |=> dot_q == '0);
endmodule

// File: rtl/raster_line_gen.sv
module raster_line_gen
  import raster_pkg::*;
#(
  parameter int VISIBLE_LINES = 224,
  parameter int TOTAL_LINES   = 262,
  parameter int LINE_W        = cnt_width(TOTAL_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end_i,
  output logic [LINE_W-1:0] line_o,
  output logic              vblank_o
);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(TOTAL_LINES - 1);

  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else if (line_end_i) begin
      if (line_q == LINE_LAST) line_q <= '0;
      else                     line_q <= line_q + LINE_W'(1);
    end
  end

  assign line_o   = line_q;
  assign vblank_o = line_in_vblank(32'(line_q), VISIBLE_LINES);

  a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end_i |=> $stable(line_q));
  a_r2_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end_i && line_q != LINE_LAST) |=> line_q == $past(line_q) + LINE_W'(1));
  a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end_i && line_q == LINE_LAST) |=> line_q == '0);
endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen #(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end_i,
  input  logic             in_visible_i,
  input  logic [IRQ_W-1:0] interval_i,
  output logic             irq_o
);
  logic [IRQ_W-1:0] cnt_q;
  logic             irq_q;
  logic             underflow;

  assign underflow = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (line_end_i) begin
        if (!in_visible_i) begin
          cnt_q <= interval_i;
        end else if (underflow) begin
          irq_q <= 1'b1;
          cnt_q <= interval_i;
        end else begin
          cnt_q <= cnt_q - IRQ_W'(1);
        end
      end
    end
  end

  assign irq_o = irq_q;

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  a_r9_pulse_needs_line_end: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end_i |=> !irq_q);
  a_r10_vblank_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end_i && !in_visible_i) |=> (!irq_q && cnt_q == $past(interval_i)));
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_pkg::*;
#(
  parameter int CLK_PER_DOT   = 10,
  parameter int DOTS_PER_LINE = 342,
  parameter int HBLANK_DOTS   = 86,
  parameter int VISIBLE_LINES = 224,
  parameter int TOTAL_LINES   = 262,
  parameter int IRQ_W         = 8,
  parameter int DOT_W         = cnt_width(DOTS_PER_LINE),
  parameter int LINE_W        = cnt_width(TOTAL_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_en_i,
  input  logic [IRQ_W-1:0]  irq_interval_i,
  output logic [DOT_W-1:0]  dot_o,
  output logic [LINE_W-1:0] line_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              active_o,
  output logic              line_irq_o
);
  localparam logic [LINE_W-1:0] VIS_L = LINE_W'(VISIBLE_LINES);

  logic tick, line_end, hb_end;
  logic den_q;

  raster_dot_gen #(
    .CLK_PER_DOT(CLK_PER_DOT), .DOTS_PER_LINE(DOTS_PER_LINE),
    .HBLANK_DOTS(HBLANK_DOTS), .DOT_W(DOT_W)
  ) u_dot (
    .clk(clk), .rst_n(rst_n), .dot_o(dot_o), .tick_o(tick),
    .line_end_o(line_end), .hb_end_o(hb_end)
  );

  raster_line_gen #(
    .VISIBLE_LINES(VISIBLE_LINES), .TOTAL_LINES(TOTAL_LINES), .LINE_W(LINE_W)
  ) u_line (
    .clk(clk), .rst_n(rst_n), .line_end_i(line_end),
    .line_o(line_o), .vblank_o(vblank_o)
  );

  raster_irq_gen #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .line_end_i(line_end),
    .in_visible_i(!vblank_o), .interval_i(irq_interval_i), .irq_o(line_irq_o)
  );

  // Enable is taken once per line, as the blanking dots run out.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      den_q <= 1'b0;
    else if (hb_end) den_q <= disp_en_i;
  end

  assign hblank_o = dot_in_hblank(32'(dot_o), HBLANK_DOTS);
  assign active_o = !hblank_o && !vblank_o && den_q;

  a_r5_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_end |=> $stable(den_q));
  a_r6_enable_taken: assert property (@(posedge clk) disable iff (!rst_n)
    hb_end |=> den_q == $past(disp_en_i));
  a_r7_active_gated: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (!hblank_o && !vblank_o));
  a_r9_irq_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq_o |-> (dot_o == '0 && hblank_o));
  a_r10_irq_after_visible: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq_o |-> (line_o != '0 && line_o <= VIS_L));
  a_r3_hblank_first_tick: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> hblank_o);
  a_r8_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !$stable(dot_o));
endmodule

// File: tb/tb_raster_timer.sv
`timescale 1ns/1ps
module tb_raster_timer;
  localparam int CPD   = 3;
  localparam int DOTS  = 12;
  localparam int HB    = 4;
  localparam int VIS   = 5;
  localparam int TOT   = 8;
  localparam int IW    = 4;
  localparam int LCLK  = CPD * DOTS;
  localparam int FRAME = LCLK * TOT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_en = 1'b0;
  logic [IW-1:0] ival = '0;
  logic [3:0] dot;
  logic [2:0] line;
  logic hblank, vblank, active, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit run_chk = 1'b0;

  always #4 clk = ~clk;

  raster_timer #(
    .CLK_PER_DOT(CPD), .DOTS_PER_LINE(DOTS), .HBLANK_DOTS(HB),
    .VISIBLE_LINES(VIS), .TOTAL_LINES(TOT), .IRQ_W(IW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .disp_en_i(disp_en), .irq_interval_i(ival),
    .dot_o(dot), .line_o(line), .hblank_o(hblank), .vblank_o(vblank),
    .active_o(active), .line_irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Bench model: positions from elapsed clocks, state updated at the same edges.
  int t;
  bit m_den;
  int m_cnt;
  bit m_irq;

  function automatic int e_dot(int tt);  return (tt / CPD) % DOTS; endfunction
  function automatic int e_line(int tt); return (tt / LCLK) % TOT; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      t <= 0; m_den <= 1'b0; m_cnt <= 0; m_irq <= 1'b0;
    end else begin : model_step
      int ended;
      t <= t + 1;
      m_irq <= 1'b0;
      if ((t % CPD) == CPD - 1 && e_dot(t) == HB - 1) m_den <= disp_en;
      if (((t + 1) % LCLK) == 0) begin
        ended = e_line(t);
        if (ended >= VIS) m_cnt <= int'(ival);
        else if (m_cnt == 0) begin m_irq <= 1'b1; m_cnt <= int'(ival); end
        else m_cnt <= m_cnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_chk) begin : cmp
      int ed, el;
      bit ehb, evb;
      ed = e_dot(t); el = e_line(t);
      ehb = (ed < HB); evb = (el >= VIS);
      chk(int'(dot) == ed, "R1 dot", int'(dot), ed);
      chk(int'(line) == el, "R2 line", int'(line), el);
      chk(hblank == ehb, "R3 hblank", int'(hblank), int'(ehb));
      chk(vblank == evb, "R4 vblank", int'(vblank), int'(evb));
      chk(active == (!ehb && !evb && m_den), "R7 active", int'(active),
          int'(!ehb && !evb && m_den));
      chk(irq == m_irq, "R9 R10 irq", int'(irq), int'(m_irq));
    end
  end

  task automatic wait_pos(input int l, input int d);
    do @(negedge clk); while (!(int'(line) == l && int'(dot) == d));
  endtask

  task automatic count_irqs(input int k, input int exp_n, input string req);
    int n = 0;
    ival = IW'(k);
    repeat (2 * FRAME) @(negedge clk);
    repeat (FRAME) begin
      @(negedge clk);
      if (irq) n++;
    end
    chk(n == exp_n, req, n, exp_n);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(dot == '0 && line == '0, "R11 counters in reset", int'(dot) + int'(line), 0);
    chk(!active && !irq && hblank && !vblank, "R11 flags in reset",
        int'({active, irq, hblank, vblank}), 2);
    rst_n = 1'b1;
    run_chk = 1'b1;

    // R9: every line, every second line; R10: vblank reload decides count
    disp_en = 1'b1;
    count_irqs(0, VIS, "R9 interval 0 pulses per frame");
    count_irqs(1, VIS / 2, "R9 interval 1 pulses per frame");
    count_irqs(2, VIS / 3, "R10 interval 2 pulses per frame");

    // R6: clear in blanking -> drawn part of the same line is blank
    disp_en = 1'b1;
    wait_pos(1, 0);
    wait_pos(1, 1);
    disp_en = 1'b0;
    wait_pos(1, HB);
    chk(active == 1'b0, "R6 cleared in hblank blanks line", int'(active), 0);
    // R6: set in blanking -> same line drawn
    wait_pos(2, 1);
    disp_en = 1'b1;
    wait_pos(2, HB);
    chk(active == 1'b1, "R6 set in hblank draws line", int'(active), 1);
    // R5: clear mid-line -> line still drawn to its last dot
    wait_pos(2, HB + 2);
    disp_en = 1'b0;
    wait_pos(2, DOTS - 1);
    chk(active == 1'b1, "R5 cleared mid-line keeps line", int'(active), 1);
    wait_pos(3, HB);
    chk(active == 1'b0, "R5 next line blanked", int'(active), 0);

    // R8: timing keeps running with display off
    begin : free_run
      int l0;
      bit seen_active = 1'b0;
      disp_en = 1'b0;
      wait_pos(0, 0);
      l0 = int'(line);
      repeat (LCLK) @(negedge clk);
      chk(int'(line) == (l0 + 1) % TOT, "R8 line advances with display off",
          int'(line), (l0 + 1) % TOT);
      repeat (FRAME) begin
        @(negedge clk);
        if (active) seen_active = 1'b1;
      end
      chk(!seen_active, "R8 no active dots with display off", int'(seen_active), 0);
    end

    // Random enable toggles and interval changes, checked every cycle
    for (int i = 0; i < 12000; i++) begin
      @(negedge clk);
      if (($urandom % 40) == 0) disp_en = ~disp_en;
      if (($urandom % 500) == 0) ival = IW'($urandom % 4);
    end

    @(negedge clk);
    run_chk = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule